// File: doc/BRIEF.md
# Parallel EEPROM Byte-Write and Completion-Poll Controller

This block sits on the host side of a self-timed parallel EEPROM. It accepts one request at a time on a valid/ready handshake. A request is either a byte write (11-bit address, 8-bit data) or a plain read. For a write it drives the address and data, then generates one low pulse on the write strobe. Output enable is kept high around that pulse, and the data is held for a short time after the strobe rises. The block then releases its data driver and reads the same address again and again. After each read it compares only the most significant bit with the bit that was written. While the memory is still programming it returns that bit inverted. A match ends the operation cleanly. A maximum write time, counted from the strobe's rising edge, ends it with an error flag.

A plain read is a single access. Chip enable and output enable are held low for an access window. The byte is sampled at the end of that window, and the bus is then given a float-recovery interval. Every interval is a parameter in clock cycles: address and data setup, strobe width, data hold, the output-enable hold and strobe-high gap, the read access window, bus float recovery and the timeout. The asynchronous data input passes through a parameterised synchronizer. The strobes are decoded from the next state and registered, so the pins carry no decode glitches.

Top module: `eep_wpoll_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `req_ready` is 1 and `rsp_valid` is 0. The strobes `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1 (inactive), and `mem_dq_oe` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the cycle after acceptance and stays 0 until the operation completes. Each accepted request produces exactly one single-cycle `rsp_valid` pulse, and responses come in request order.
- R3: For a write (`req_write`=1), `mem_we_n` goes low exactly once. It stays low for exactly T_WPL cycles, it falls at least T_ASU cycles after the address was applied, and `mem_addr` equals the request address and is stable for the whole low time.
- R4: `mem_dq_oe` is 1 and `mem_dq_out` equals the written byte throughout the strobe-low time and in the cycle in which `mem_we_n` rises. `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R5: `mem_oe_n` is 1 whenever `mem_we_n` is 0. After `mem_we_n` rises, `mem_oe_n` stays 1 for at least T_OEH cycles.
- R6: After the strobe, the controller reads the written address with `mem_ce_n`=0 and `mem_oe_n`=0 for T_ACC cycles and samples the byte at the end of that window. If bit 7 of the sampled byte equals bit 7 of the written byte, it responds with `rsp_error`=0 and `rsp_rdata` equal to the sampled byte. A memory that is already finished gives exactly one poll read.
- R7: If bit 7 is the inverse of the written bit, the controller raises `mem_oe_n` and `mem_ce_n` for T_FLOAT cycles and then reads the same address again. It keeps doing so until the bits match or the timeout expires.
- R8: If no poll read matches within TIMEOUT cycles after `mem_we_n` rises, the response has `rsp_error`=1 and `rsp_rdata` equal to the last sampled byte.
- R9: A read (`req_write`=0) performs exactly one access of T_ACC cycles at the request address, with `mem_dq_oe`=0. It responds with `rsp_error`=0 and `rsp_rdata` equal to the byte on `mem_dq_in` at the end of the access.
- R10: After `mem_oe_n` rises, `mem_dq_oe` stays 0 for at least T_FLOAT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = byte write with poll, 0 = read |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Write poll timed out (valid with rsp_valid) |
| rsp_rdata | output | 8 | Byte read, or last polled byte for a write |
| mem_addr | output | 11 | Address to the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable of the host data driver |
| mem_dq_in | input | 8 | Data bus as seen from the memory side |

## Verification
The assertions assume that `req_valid` and its payload stay steady until the request is taken. They also assume that the memory puts data on `mem_dq_in` only while both its chip and output enables are low. The value must be settled for at least the synchronizer depth before the end of the access window. The bench meets these conditions: its driver changes request signals only on falling clock edges and holds them until `req_ready` has been seen. Its memory model updates the read value and its busy state only on rising clock edges, so every value reaching the synchronizer is a clean, clock-aligned level.

// File: rtl/eep_wpoll_pkg.sv
package eep_wpoll_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_WSET = 3'd1,
      ST_WPUL = 3'd2,
      ST_WHLD = 3'd3,
      ST_WGAP = 3'd4,
      ST_ACC  = 3'd5,
      ST_REC  = 3'd6
   } wp_state_e;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic dq_oe;
   } wp_pins_t;

   function automatic int unsigned wp_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic wp_pins_t wp_decode(input wp_state_e s);
      wp_pins_t p;
      p.ce_n  = !(s inside {ST_WSET, ST_WPUL, ST_WHLD, ST_WGAP, ST_ACC});
      p.oe_n  = (s != ST_ACC);
      p.we_n  = (s != ST_WPUL);
      p.dq_oe = (s inside {ST_WSET, ST_WPUL, ST_WHLD});
      return p;
   endfunction

endpackage

// File: rtl/eep_wpoll_tick.sv
module eep_wpoll_tick #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] len,
   output logic         last
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= len - W'(1);
      else if (cnt != '0)
         cnt <= cnt - W'(1);
   end

   assign last = (cnt == '0);

endmodule

// File: rtl/eep_wpoll_tmo.sv
module eep_wpoll_tmo #(
   parameter int LIMIT = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic expired
);

   localparam int TW = $clog2(LIMIT + 1);

   logic [TW-1:0] cnt;

   assign expired = (cnt >= TW'(LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (!expired)
         cnt <= cnt + TW'(1);
   end

endmodule

// File: rtl/eep_wpoll_rdsync.sv
module eep_wpoll_rdsync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_flops
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/eep_wpoll_pins.sv
module eep_wpoll_pins
   import eep_wpoll_pkg::*;
#(
   parameter bit REG_PINS = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  wp_state_e st_src,
   output wp_pins_t  pins
);

   localparam wp_pins_t PINS_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

   generate
      if (REG_PINS) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pins <= PINS_IDLE;
            else
               pins <= wp_decode(st_src);
         end
      end else begin : g_comb
         assign pins = wp_decode(st_src);
      end
   endgenerate

endmodule

// File: rtl/eep_wpoll_ctrl.sv
module eep_wpoll_ctrl
   import eep_wpoll_pkg::*;
#(
   parameter int AW       = 11,
   parameter int DW       = 8,
   parameter int T_ASU    = 2,
   parameter int T_WPL    = 10,
   parameter int T_WPH    = 5,
   parameter int T_DH     = 1,
   parameter int T_OEH    = 2,
   parameter int T_ACC    = 8,
   parameter int T_FLOAT  = 5,
   parameter int TIMEOUT  = 100000,
   parameter int RD_SYNC  = 2,
   parameter bit REG_PINS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_valid,
   output logic          rsp_error,
   output logic [DW-1:0] rsp_rdata,
   output logic [AW-1:0] mem_addr,
   output logic          mem_ce_n,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   output logic [DW-1:0] mem_dq_out,
   output logic          mem_dq_oe,
   input  logic [DW-1:0] mem_dq_in
);

   localparam int GAP  = wp_max(T_OEH, T_WPH);
   localparam int LMAX = wp_max(wp_max(wp_max(T_ASU, T_WPL), wp_max(T_DH, GAP)),
                                wp_max(T_ACC, T_FLOAT));
   localparam int CW   = $clog2(LMAX + 1);

   generate
      if (AW < 1 || DW < 2) begin : g_bad_width
         $error("eep_wpoll_ctrl: AW must be >= 1 and DW >= 2");
      end
      if (T_ASU < 1 || T_WPL < 1 || T_DH < 1 || GAP < 1 || T_FLOAT < 1) begin : g_bad_time
         $error("eep_wpoll_ctrl: every interval must be at least one cycle");
      end
      if (T_ACC <= RD_SYNC) begin : g_bad_acc
         $error("eep_wpoll_ctrl: T_ACC must exceed the synchronizer depth");
      end
      if (TIMEOUT < 1) begin : g_bad_tmo
         $error("eep_wpoll_ctrl: TIMEOUT must be positive");
      end
   endgenerate

   wp_state_e     st, st_nxt;
   logic          load;
   logic [CW-1:0] len;
   logic          last;
   logic          expired;
   logic [DW-1:0] rd_byte;
   wp_pins_t      pins;
   wp_state_e     pin_src;

   logic          op_wr;
   logic [AW-1:0] a_q;
   logic [DW-1:0] d_q;
   logic          fin, err_q;
   logic [DW-1:0] rdata_q;
   logic          rsp_q;

   logic          accept;
   logic          sample;
   logic          bit_ok;

   assign accept = (st == ST_IDLE) && req_valid;
   assign sample = (st == ST_ACC) && last;
   assign bit_ok = (rd_byte[DW-1] == d_q[DW-1]);

   always_comb begin
      st_nxt = st;
      load   = 1'b0;
      len    = '0;
      unique case (st)
         ST_IDLE: if (req_valid) begin
            load   = 1'b1;
            st_nxt = req_write ? ST_WSET : ST_ACC;
            len    = req_write ? CW'(T_ASU) : CW'(T_ACC);
         end
         ST_WSET: if (last) begin
            st_nxt = ST_WPUL; load = 1'b1; len = CW'(T_WPL);
         end
         ST_WPUL: if (last) begin
            st_nxt = ST_WHLD; load = 1'b1; len = CW'(T_DH);
         end
         ST_WHLD: if (last) begin
            st_nxt = ST_WGAP; load = 1'b1; len = CW'(GAP);
         end
         ST_WGAP: if (last) begin
            st_nxt = ST_ACC; load = 1'b1; len = CW'(T_ACC);
         end
         ST_ACC: if (last) begin
            st_nxt = ST_REC; load = 1'b1; len = CW'(T_FLOAT);
         end
         ST_REC: if (last) begin
            if (fin) begin
               st_nxt = ST_IDLE;
            end else begin
               st_nxt = ST_ACC; load = 1'b1; len = CW'(T_ACC);
            end
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         op_wr   <= 1'b0;
         a_q     <= '0;
         d_q     <= '0;
         fin     <= 1'b0;
         err_q   <= 1'b0;
         rdata_q <= '0;
         rsp_q   <= 1'b0;
      end else begin
         st    <= st_nxt;
         rsp_q <= (st == ST_REC) && last && fin;
         if (accept) begin
            op_wr <= req_write;
            a_q   <= req_addr;
            d_q   <= req_wdata;
            fin   <= 1'b0;
            err_q <= 1'b0;
         end
         if (sample) begin
            rdata_q <= rd_byte;
            if (!op_wr) begin
               fin   <= 1'b1;
               err_q <= 1'b0;
            end else begin
               fin   <= bit_ok || expired;
               err_q <= !bit_ok && expired;
            end
         end
      end
   end

   eep_wpoll_tick #(.W(CW)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .len   (len),
      .last  (last)
   );

   eep_wpoll_tmo #(.LIMIT(TIMEOUT)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   ((st == ST_WPUL) && last),
      .expired (expired)
   );

   eep_wpoll_rdsync #(.W(DW), .STAGES(RD_SYNC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (mem_dq_in),
      .q     (rd_byte)
   );

   assign pin_src = REG_PINS ? st_nxt : st;

   eep_wpoll_pins #(.REG_PINS(REG_PINS)) u_pins (
      .clk    (clk),
      .rst_n  (rst_n),
      .st_src (pin_src),
      .pins   (pins)
   );

   assign req_ready  = (st == ST_IDLE);
   assign rsp_valid  = rsp_q;
   assign rsp_error  = err_q;
   assign rsp_rdata  = rdata_q;
   assign mem_addr   = a_q;
   assign mem_dq_out = d_q;
   assign mem_ce_n   = pins.ce_n;
   assign mem_oe_n   = pins.oe_n;
   assign mem_we_n   = pins.we_n;
   assign mem_dq_oe  = pins.dq_oe;

endmodule

// File: rtl/eep_wpoll_chk.sv
module eep_wpoll_chk #(
   parameter int AW      = 11,
   parameter int DW      = 8,
   parameter int T_WPL   = 10,
   parameter int T_FLOAT = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          rsp_valid,
   input logic [AW-1:0] mem_addr,
   input logic          mem_ce_n,
   input logic          mem_oe_n,
   input logic          mem_we_n,
   input logic [DW-1:0] mem_dq_out,
   input logic          mem_dq_oe
);

   localparam int LW = $clog2(T_WPL + 2);
   localparam int FW = $clog2(T_FLOAT + 2);
   localparam logic [FW-1:0] FMAX = {FW{1'b1}};

   logic [LW-1:0] wl_cnt;
   logic [FW-1:0] fl_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wl_cnt <= '0;
         fl_cnt <= FMAX;
      end else begin
         if (!mem_we_n) begin
            if (wl_cnt != {LW{1'b1}}) wl_cnt <= wl_cnt + LW'(1);
         end else begin
            wl_cnt <= '0;
         end
         if (!mem_oe_n)
            fl_cnt <= '0;
         else if (fl_cnt != FMAX)
            fl_cnt <= fl_cnt + FW'(1);
      end
   end

   // R2
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R2
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R3
   we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (wl_cnt == LW'(T_WPL)));

   // R3
   we_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> ($stable(mem_addr) && !mem_ce_n));

   // R4
   we_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_dq_oe && $stable(mem_dq_out)));

   // R4
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe);

   // R5
   oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

   // R6
   read_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_ce_n && mem_we_n));

   // R10
   float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && !$past(mem_dq_oe)) |-> (fl_cnt >= FW'(T_FLOAT)));

endmodule

bind eep_wpoll_ctrl eep_wpoll_chk #(
   .AW(AW), .DW(DW), .T_WPL(T_WPL), .T_FLOAT(T_FLOAT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .mem_addr   (mem_addr),
   .mem_ce_n   (mem_ce_n),
   .mem_oe_n   (mem_oe_n),
   .mem_we_n   (mem_we_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_eep_wpoll_ctrl.sv
`timescale 1ns/1ps
module tb_eep_wpoll_ctrl;

   localparam int AW = 11, DW = 8;
   localparam int T_ASU = 2, T_WPL = 10, T_WPH = 5, T_DH = 1, T_OEH = 2;
   localparam int T_ACC = 8, T_FLOAT = 5, TIMEOUT = 600;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_valid, rsp_error;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_out, mem_dq_in;

   always #5 clk = ~clk;

   eep_wpoll_ctrl #(
      .AW(AW), .DW(DW), .T_ASU(T_ASU), .T_WPL(T_WPL), .T_WPH(T_WPH), .T_DH(T_DH),
      .T_OEH(T_OEH), .T_ACC(T_ACC), .T_FLOAT(T_FLOAT), .TIMEOUT(TIMEOUT),
      .RD_SYNC(2), .REG_PINS(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   int n_chk = 0, n_fail = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [DW-1:0] mem [0:(1<<AW)-1];
   int            busy = 0;
   int            next_busy = 0;
   logic [AW-1:0] p_a = '0;
   logic [DW-1:0] p_d = '0;
   logic          we_prev = 1'b1;
   logic [DW-1:0] rd_val;

   initial for (int i = 0; i < (1<<AW); i++) mem[i] = 8'(i) ^ 8'hA5;

   assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? rd_val : 8'h00;

   always @(posedge clk) begin
      if (busy > 0) begin
         if (rsp_valid && rsp_error) begin
            mem[p_a] = p_d;
            busy = 0;
         end else begin
            busy = busy - 1;
            if (busy == 0) mem[p_a] = p_d;
         end
      end
      if (rst_n && mem_we_n && !we_prev && !mem_ce_n) begin
         p_a = mem_addr;
         p_d = mem_dq_out;
         if (next_busy == 0) mem[p_a] = p_d;
         else busy = next_busy;
      end
      we_prev = mem_we_n;
      rd_val  = (busy != 0) ? {~p_d[7], 7'h2A} : mem[mem_addr];
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      string         tag;
      logic          err;
      logic [DW-1:0] rd;
      int            polls;   // >0 exact count, -1 means more than one
   } exp_t;

   exp_t q[$];
   logic [AW-1:0] cur_a = '0;
   logic [DW-1:0] cur_d = '0;

   task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int busy_len, input logic e, input logic [DW-1:0] rd,
                        input int polls, input string tag);
      exp_t x;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      x.tag = tag; x.err = e; x.rd = rd; x.polls = polls;
      q.push_back(x);
      cur_a = a; cur_d = d; next_busy = busy_len;
      #1;
      req_valid = 1'b0;
      chk({"R2 ready low after accept ", tag}, 32'(req_ready), 32'd0);
   endtask

   // ---------------- monitor ----------------
   int  we_low = 0, oe_hi_after_we = 0, since_oe_hi = 1000, polls = 0;
   bit  after_write = 0;
   logic m_we_prev = 1'b1, m_oe_prev = 1'b1, m_dqoe_prev = 1'b0;

   always @(negedge clk) if (rst_n) begin
      if (mem_dq_oe && !mem_oe_n) chk("R4 driver on during read", 32'd1, 32'd0);
      if (!mem_we_n) begin
         we_low++;
         if (mem_addr !== cur_a) chk("R3 address during strobe", 32'(mem_addr), 32'(cur_a));
         if (!mem_oe_n) chk("R5 output enable low during strobe", 32'(mem_oe_n), 32'd1);
      end
      if (mem_we_n && !m_we_prev) begin
         chk("R3 strobe width", 32'(we_low), 32'(T_WPL));
         chk("R4 data at strobe rise", {23'd0, mem_dq_oe, mem_dq_out}, {23'd0, 1'b1, cur_d});
         we_low = 0; after_write = 1; oe_hi_after_we = 0;
      end
      if (after_write && mem_oe_n && mem_we_n) oe_hi_after_we++;
      if (!mem_oe_n && m_oe_prev) begin
         polls++;
         if (after_write) begin
            chk("R5 output enable hold after strobe", 32'(oe_hi_after_we >= T_OEH), 32'd1);
            after_write = 0;
         end
      end
      if (mem_dq_oe && !m_dqoe_prev)
         chk("R10 bus float before drive", 32'(since_oe_hi >= T_FLOAT), 32'd1);
      if (!mem_oe_n) since_oe_hi = 0;
      else if (since_oe_hi < 1000) since_oe_hi++;
      if (rsp_valid) begin
         if (q.size() == 0) chk("R2 unexpected response", 32'd1, 32'd0);
         else begin
            exp_t x;
            x = q.pop_front();
            chk({x.tag, " error"}, 32'(rsp_error), 32'(x.err));
            chk({x.tag, " data"}, 32'(rsp_rdata), 32'(x.rd));
            if (x.polls > 0) chk({x.tag, " poll count"}, 32'(polls), 32'(x.polls));
            else chk({x.tag, " repeated polls"}, 32'(polls > 1), 32'd1);
         end
         polls = 0;
      end
      m_we_prev = mem_we_n; m_oe_prev = mem_oe_n; m_dqoe_prev = mem_dq_oe;
   end

   // ---------------- watchdog ----------------
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=<60000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", 32'(req_ready), 32'd1);
      chk("R1 strobes in reset", {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'd7);
      chk("R1 driver off in reset", 32'(mem_dq_oe), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle after reset", {28'd0, req_ready, rsp_valid, mem_we_n, mem_dq_oe}, 32'b1010);

      // R9: plain read of preloaded byte (addr 0x005 -> 0x05^0xA5)
      issue(0, 11'h005, 8'h00, 0, 1'b0, 8'hA0, 1, "R9 read preload");
      // R6: memory already finished, one poll, bit 7 = 1
      issue(1, 11'h123, 8'h81, 0, 1'b0, 8'h81, 1, "R6 write quick");
      // R7: busy memory, bit 7 = 0 polled inverted several times
      issue(1, 11'h124, 8'h3C, 60, 1'b0, 8'h3C, -1, "R7 write busy low bit");
      issue(0, 11'h124, 8'h00, 0, 1'b0, 8'h3C, 1, "R9 read back busy low bit");
      // R7: top address, bit 7 = 1
      issue(1, 11'h7FF, 8'hFF, 35, 1'b0, 8'hFF, -1, "R7 write busy high bit");
      issue(0, 11'h7FF, 8'h00, 0, 1'b0, 8'hFF, 1, "R9 read back top address");
      // R8: memory never finishes within TIMEOUT
      issue(1, 11'h000, 8'h00, 100000, 1'b1, 8'hAA, -1, "R8 write timeout");
      issue(0, 11'h000, 8'h00, 0, 1'b0, 8'h00, 1, "R9 read after timeout");
      // R10: write directly after a read, then read back
      issue(1, 11'h400, 8'h5A, 20, 1'b0, 8'h5A, -1, "R10 write after read");
      issue(0, 11'h400, 8'h00, 0, 1'b0, 8'h5A, 1, "R9 read back mid address");

      while (q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule